// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Control Registers

This block holds the software-visible control state for one channel of a bus-master disk DMA engine. A small byte-addressed register port lets software set the transfer direction, start and stop the transfer, load the address of the descriptor table, and read and acknowledge the channel status. The block drives a start level and a direction level to a separate transfer engine. In return, the engine reports completion, errors and the device interrupt.

Two helper outputs support the driver's end-of-transfer and timeout handling. The end verdict is recomputed every cycle from the status byte. It reads zero only for a clean finish, and otherwise gives the status value with bit 4 forced on. A one-cycle timeout request produces a registered classification: keep waiting, fail, or reset the bus.

Top module: `dmac_chan_regs`

## Requirements
- R1: The register map is as follows. Offset 0 is the command byte and offset 2 is the status byte. Offsets 4 to 7 hold the descriptor-table pointer, least significant byte at offset 4. Offsets 1 and 3 read zero and ignore writes. Read data is registered and reflects the address presented one cycle earlier.
- R2: Command bit 0 drives `eng_start`. Command bit 3 drives `eng_to_mem`, where 1 means the device writes into memory. The command byte reads back with only bits 0 and 3 kept.
- R3: Status bit 0 (active) behaves as follows. It sets when a command write changes bit 0 from 0 to 1. It clears on an `eng_done` pulse, or on any command write with bit 0 equal to 0. Writing 1 to bit 0 when it is already 1 does not set it again.
- R4: Status bit 1 (error) sets while `eng_err` is high. Status bit 2 (interrupt) sets on a rising edge of `dev_irq`, not on its level. Each bit holds until software writes 1 to it at offset 2. Writing 0 to these bits has no effect. A set in the same cycle as a clear leaves the bit set.
- R5: Status bits 3 and 4 are plain read/write bits. Bits 5 and 6 are read/write drive-0 and drive-1 DMA-capable flags. Bit 7 reads zero. A status write does not disturb bits 0 to 2 unless it writes 1 to bit 1 or bit 2.
- R6: `end_verdict` is updated one cycle after the status byte changes. It is 0x00 when status bits [2:0] equal 100b, and otherwise equals 0x10 OR status.
- R7: A `tmo_req` pulse raises `tmo_valid` for one cycle on the next cycle, with `tmo_class` set by the first matching rule:
  - status bits 3 and 4 both set gives 0 (wait);
  - error set gives 1 (fail);
  - active set gives 0 (wait);
  - interrupt set gives 0 (wait);
  - otherwise the result is 2 (reset bus).
- R8: The pointer's two low bits always read zero.
- R9: Pointer writes are ignored while status bit 0 is set. Start may be written before or after the pointer.
- R10: After reset, the command, pointer, active, error, interrupt and bits 3 to 4 are zero, and the drive flags equal the parameter `DRV_CAP_RST` (default 00). `end_verdict` is 0x10, and `tmo_valid` and `reg_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Byte write strobe |
| reg_addr | input | 3 | Byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Engine error indication |
| dev_irq | input | 1 | Device interrupt level |
| eng_start | output | 1 | Start level to engine |
| eng_to_mem | output | 1 | Direction: 1 = device to memory |
| tbl_ptr | output | 32 | Descriptor-table pointer |
| end_verdict | output | 8 | End-of-transfer verdict |
| tmo_req | input | 1 | Timeout classification request |
| tmo_valid | output | 1 | Classification valid |
| tmo_class | output | 2 | 0 wait, 1 fail, 2 reset bus |

## Verification
A wrong active flag shows up at the ports in two ways. The status read and `end_verdict` are wrong within one and two cycles. Pointer writes are accepted or dropped when they should not be, and this appears on `tbl_ptr` on the next cycle.

A stuck or lost error or interrupt bit changes `end_verdict` one cycle later. It also changes the next timeout class. A level-triggered interrupt latch in place of an edge-triggered one appears as an interrupt bit that returns right after it is acknowledged while `dev_irq` stays high.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int CMD_GO  = 0;
  localparam int CMD_DIR = 3;
  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_IRQ  = 2;
  localparam int OFS_CMD  = 0;
  localparam int OFS_STAT = 2;

  typedef enum logic [1:0] {
    TMO_WAIT  = 2'd0,
    TMO_FAIL  = 2'd1,
    TMO_RESET = 2'd2
  } tmo_class_e;
endpackage

// File: rtl/dmac_status.sv
module dmac_status #(
  parameter logic [1:0] DRV_CAP_RST = 2'b00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stat,
  input  logic [7:0] wdata,
  input  logic       go_rise,
  input  logic       go_stop,
  input  logic       eng_done,
  input  logic       eng_err,
  input  logic       dev_irq,
  output logic [7:0] status
);
  import dmac_pkg::*;

  logic       act_q, err_q, irq_q, irq_d1;
  logic [1:0] aux_q, cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
      irq_d1 <= 1'b0;
      aux_q  <= 2'b00;
      cap_q  <= DRV_CAP_RST;
    end else begin
      irq_d1 <= dev_irq;
      if (go_rise)                  act_q <= 1'b1;
      else if (go_stop || eng_done) act_q <= 1'b0;
      if (eng_err)                         err_q <= 1'b1;
      else if (wr_stat && wdata[ST_ERR])   err_q <= 1'b0;
      if (dev_irq && !irq_d1)              irq_q <= 1'b1;
      else if (wr_stat && wdata[ST_IRQ])   irq_q <= 1'b0;
      if (wr_stat) begin
        aux_q <= wdata[4:3];
        cap_q <= wdata[6:5];
      end
    end
  end

  assign status = {1'b0, cap_q, aux_q, irq_q, err_q, act_q};
endmodule

// File: rtl/dmac_ptr.sv
module dmac_ptr #(
  parameter  int PTR_W     = 32,
  localparam int PTR_BYTES = PTR_W / 8,
  localparam int SEL_W     = $clog2(PTR_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             lock,
  input  logic [SEL_W-1:0] sel,
  input  logic [7:0]       wdata,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (wr_en && !lock) begin
      for (int b = 0; b < PTR_BYTES; b++) begin
        if (sel == SEL_W'(b))
          ptr_q[8*b +: 8] <= (b == 0) ? (wdata & 8'hFC) : wdata;
      end
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/dmac_verdict.sv
module dmac_verdict (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] status,
  input  logic       tmo_req,
  output logic [7:0] end_verdict,
  output logic       tmo_valid,
  output logic [1:0] tmo_class
);
  import dmac_pkg::*;

  tmo_class_e cls_d;
  logic [7:0] verdict_d;

  always_comb begin
    if (status[3] && status[4])  cls_d = TMO_WAIT;
    else if (status[ST_ERR])     cls_d = TMO_FAIL;
    else if (status[ST_ACT])     cls_d = TMO_WAIT;
    else if (status[ST_IRQ])     cls_d = TMO_WAIT;
    else                         cls_d = TMO_RESET;
    verdict_d = (status[2:0] == 3'b100) ? 8'h00 : (8'h10 | status);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      end_verdict <= 8'h10;
      tmo_valid   <= 1'b0;
      tmo_class   <= TMO_WAIT;
    end else begin
      end_verdict <= verdict_d;
      tmo_valid   <= tmo_req;
      if (tmo_req) tmo_class <= cls_d;
    end
  end
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs #(
  parameter  int         PTR_W       = 32,
  parameter  logic [1:0] DRV_CAP_RST = 2'b00,
  localparam int         PTR_BYTES   = PTR_W / 8,
  localparam int         SEL_W       = $clog2(PTR_BYTES),
  localparam int         ADDR_W      = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              dev_irq,
  output logic              eng_start,
  output logic              eng_to_mem,
  output logic [PTR_W-1:0]  tbl_ptr,
  output logic [7:0]        end_verdict,
  input  logic              tmo_req,
  output logic              tmo_valid,
  output logic [1:0]        tmo_class
);
  import dmac_pkg::*;

  logic       go_q, dir_q;
  logic       wr_cmd, wr_stat, wr_ptr, go_rise, go_stop;
  logic [7:0] status_q;
  logic       in_ptr;

  assign in_ptr  = reg_addr[ADDR_W-1];
  assign wr_cmd  = reg_we && (reg_addr == ADDR_W'(OFS_CMD));
  assign wr_stat = reg_we && (reg_addr == ADDR_W'(OFS_STAT));
  assign wr_ptr  = reg_we && in_ptr;
  assign go_rise = wr_cmd && reg_wdata[CMD_GO] && !go_q;
  assign go_stop = wr_cmd && !reg_wdata[CMD_GO];

  always_ff @(posedge clk) begin
    if (rst) begin
      go_q  <= 1'b0;
      dir_q <= 1'b0;
    end else if (wr_cmd) begin
      go_q  <= reg_wdata[CMD_GO];
      dir_q <= reg_wdata[CMD_DIR];
    end
  end

  assign eng_start  = go_q;
  assign eng_to_mem = dir_q;

  dmac_status #(.DRV_CAP_RST(DRV_CAP_RST)) u_status (
    .clk(clk), .rst(rst), .wr_stat(wr_stat), .wdata(reg_wdata),
    .go_rise(go_rise), .go_stop(go_stop), .eng_done(eng_done),
    .eng_err(eng_err), .dev_irq(dev_irq), .status(status_q)
  );

  dmac_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .wr_en(wr_ptr), .lock(status_q[ST_ACT]),
    .sel(reg_addr[SEL_W-1:0]), .wdata(reg_wdata), .ptr(tbl_ptr)
  );

  dmac_verdict u_verdict (
    .clk(clk), .rst(rst), .status(status_q), .tmo_req(tmo_req),
    .end_verdict(end_verdict), .tmo_valid(tmo_valid), .tmo_class(tmo_class)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= 8'h00;
    end else if (in_ptr) begin
      reg_rdata <= tbl_ptr[8*reg_addr[SEL_W-1:0] +: 8];
    end else if (reg_addr == ADDR_W'(OFS_CMD)) begin
      reg_rdata <= {4'b0, dir_q, 2'b0, go_q};
    end else if (reg_addr == ADDR_W'(OFS_STAT)) begin
      reg_rdata <= status_q;
    end else begin
      reg_rdata <= 8'h00;
    end
  end
endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk #(
  parameter int PTR_W  = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              eng_done,
  input logic              eng_start,
  input logic [7:0]        status,
  input logic [PTR_W-1:0]  tbl_ptr,
  input logic [7:0]        end_verdict,
  input logic              tmo_req,
  input logic              tmo_valid,
  input logic [1:0]        tmo_class
);
  // R3
  go_edge_sets_active_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 0 && reg_wdata[0] && !eng_start) |=> status[0]);

  // R3
  done_clears_active_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_done && !(reg_we && reg_addr == 0 && reg_wdata[0] && !eng_start)) |=> !status[0]);

  // R4
  irq_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (status[2] && !(reg_we && reg_addr == 2 && reg_wdata[2])) |=> status[2]);

  // R9
  ptr_locked_chk: assert property (@(posedge clk) disable iff (rst)
    status[0] |=> $stable(tbl_ptr));

  // R6
  clean_end_chk: assert property (@(posedge clk) disable iff (rst)
    (status[2:0] == 3'b100) |=> (end_verdict == 8'h00));

  // R7
  tmo_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (tmo_req && status[1] && !(status[3] && status[4])) |=> (tmo_valid && tmo_class == 2'd1));
endmodule

bind dmac_chan_regs dmac_chan_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .eng_done(eng_done), .eng_start(eng_start),
  .status(status_q), .tbl_ptr(tbl_ptr), .end_verdict(end_verdict),
  .tmo_req(tmo_req), .tmo_valid(tmo_valid), .tmo_class(tmo_class)
);

// File: tb/dmac_chan_regs_bench.sv
module dmac_chan_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        eng_done = 1'b0, eng_err = 1'b0, dev_irq = 1'b0, tmo_req = 1'b0;
  logic        eng_start, eng_to_mem, tmo_valid;
  logic [31:0] tbl_ptr;
  logic [7:0]  end_verdict;
  logic [1:0]  tmo_class;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_chan_regs u_dmac_chan_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_done(eng_done),
    .eng_err(eng_err), .dev_irq(dev_irq), .eng_start(eng_start),
    .eng_to_mem(eng_to_mem), .tbl_ptr(tbl_ptr), .end_verdict(end_verdict),
    .tmo_req(tmo_req), .tmo_valid(tmo_valid), .tmo_class(tmo_class)
  );

  // [13] act [12] err [11] irq [10] bits3+4 | [9:2] verdict | [1:0] class
  localparam logic [13:0] VEC [8] = '{
    {4'b0010, 8'h00, 2'd0},
    {4'b0000, 8'h10, 2'd2},
    {4'b1000, 8'h11, 2'd0},
    {4'b0110, 8'h16, 2'd1},
    {4'b1101, 8'h1B, 2'd0},
    {4'b0100, 8'h12, 2'd1},
    {4'b1010, 8'h15, 2'd0},
    {4'b0001, 8'h18, 2'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    tick();
    d = reg_rdata;
  endtask

  task automatic pulse_err();
    eng_err = 1'b1; tick(); eng_err = 1'b0;
  endtask

  task automatic pulse_irq();
    dev_irq = 1'b1; tick(); dev_irq = 1'b0; tick();
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R10 reset state
    rd(0, d); check("R10 cmd", d, 8'h00);
    rd(2, d); check("R10 status", d, 8'h00);
    rd(7, d); check("R10 ptr", d, 8'h00);
    check("R10 ptr port", tbl_ptr, 32'h0);
    check("R10 verdict", end_verdict, 8'h10);
    check("R10 tmo_valid", tmo_valid, 1'b0);

    // R1 reserved bytes
    wr(1, 8'hFF); wr(3, 8'hFF);
    rd(1, d); check("R1 off1", d, 8'h00);
    rd(3, d); check("R1 off3", d, 8'h00);

    // R2 command bits
    wr(0, 8'hFF);
    rd(0, d); check("R2 cmd readback", d, 8'h09);
    check("R2 start", eng_start, 1'b1);
    check("R2 dir", eng_to_mem, 1'b1);
    rd(2, d); check("R3 active set", d, 8'h01);
    // R9 pointer locked while active
    wr(4, 8'h40); rd(4, d); check("R9 ptr locked", d, 8'h00);
    eng_done = 1'b1; tick(); eng_done = 1'b0;
    rd(2, d); check("R3 done clears", d, 8'h00);
    wr(0, 8'h09);
    rd(2, d); check("R3 no re-edge", d, 8'h00);
    wr(0, 8'h00);
    check("R2 stop", eng_start, 1'b0);
    check("R2 dir low", eng_to_mem, 1'b0);

    // R8 / R1 pointer
    wr(4, 8'hFF); wr(5, 8'h12); wr(6, 8'h34); wr(7, 8'h56);
    rd(4, d); check("R8 low bits", d, 8'hFC);
    check("R1 ptr order", tbl_ptr, 32'h563412FC);
    // R3 stop by write 0
    wr(0, 8'h01); rd(2, d); check("R3 start", d, 8'h01);
    wr(0, 8'h00); rd(2, d); check("R3 write0 clears", d, 8'h00);

    // R4 latch and W1C
    pulse_irq(); rd(2, d); check("R4 irq latched", d, 8'h04);
    pulse_err(); rd(2, d); check("R4 err set", d, 8'h06);
    wr(2, 8'h00); rd(2, d); check("R4 zero write", d, 8'h06);
    wr(2, 8'h02); rd(2, d); check("R4 clear err", d, 8'h04);
    wr(2, 8'h04); rd(2, d); check("R4 clear irq", d, 8'h00);
    eng_err = 1'b1; wr(2, 8'h02); eng_err = 1'b0;
    rd(2, d); check("R4 set wins", d, 8'h02);
    wr(2, 8'h02);
    dev_irq = 1'b1; tick(); tick();
    wr(2, 8'h04); tick();
    rd(2, d); check("R4 edge only", d, 8'h00);
    dev_irq = 1'b0; tick();

    // R5 drive flags and other bits
    pulse_irq();
    wr(2, 8'h20); rd(2, d); check("R5 drive0", d, 8'h24);
    wr(2, 8'h40); rd(2, d); check("R5 drive1", d, 8'h44);
    wr(2, 8'h80); rd(2, d); check("R5 bit7 zero", d, 8'h04);

    // R6 / R7 table
    for (int i = 0; i < 8; i++) begin
      logic [13:0] v;
      v = VEC[i];
      wr(0, 8'h00); wr(2, 8'h06); tick();
      if (v[13]) wr(0, 8'h01);
      if (v[12]) pulse_err();
      if (v[11]) pulse_irq();
      if (v[10]) wr(2, 8'h18);
      tick(); tick();
      check($sformatf("R6 verdict vec%0d", i), end_verdict, v[9:2]);
      tmo_req = 1'b1; tick(); tmo_req = 1'b0;
      check($sformatf("R7 valid vec%0d", i), tmo_valid, 1'b1);
      check($sformatf("R7 class vec%0d", i), tmo_class, v[1:0]);
      tick();
      check($sformatf("R7 single vec%0d", i), tmo_valid, 1'b0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule